// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects 32 main interrupt lines and 11 secondary sub-source lines and presents a single interrupt request to a processor. Groups of sub-sources from three serial ports and an analogue front end are gated by a sub-mask and merged, one group per line, into four fixed main lines. Main events are latched into a source-pending register. A main mask then hides chosen sources from arbitration. An arbiter moves the lowest-numbered unmasked pending source into a one-hot interrupt-pending register, and that register drives the request output.

Software uses a small synchronous register bus with a 3-bit address, a write strobe and 32-bit data. Reads are combinational. Pending registers are cleared by writing 1 to a bit. A full acknowledge writes the same one-hot value to the source-pending register and to the interrupt-pending register. For a cascaded source, the sub-pending bit is cleared first.

Register addresses: 0 source pending (write 1 clears), 1 main mask, 2 interrupt pending (write 1 clears), 3 sub pending (write 1 clears, bits 10:0), 4 sub mask (bits 10:0), 5 source set (write 1 sets, reads 0).

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, the main mask reads 0xFFFFFFFF and the sub mask reads 0x7FF. Source pending, interrupt pending and sub pending all read 0, and irq_o is 0.
- R2: A 1 on src_i[n] at a clock edge sets source-pending bit n at that edge. Lines 6 and 24 are reserved and never become pending, whether from src_i or from a set write.
- R3: Writing 1s to address 0 clears those source-pending bits. Writing 1s to address 5 sets them.
- R4: If a source event and a software clear of the same source-pending bit fall in the same cycle, the bit stays set.
- R5: A main-mask bit of 1 keeps its pending source out of arbitration but does not stop the source from latching. A main-mask bit of 0 lets the source take part.
- R6: The interrupt-pending register holds at most one bit. It loads the lowest-numbered pending source whose mask bit is 0, one edge after it becomes pending. It loads only while it is empty, so a newly pending lower source does not replace a bit that is already held.
- R7: Writing 1s to address 2 clears interrupt-pending bits. irq_o is 1 exactly when interrupt pending is non-zero. After a full acknowledge, the next pending source is loaded.
- R8: The sub-source groups are: bits 2:0 (receive, transmit, error of serial port 0) feed main line 28; bits 5:3 (port 1) feed line 23; bits 8:6 (port 2) feed line 15; bit 9 (touch) and bit 10 (conversion) feed line 31. A parent line is active while any of its sub-pending bits is set with its sub-mask bit at 0. src_i has no effect on lines 15, 23, 28 and 31.
- R9: A sub_i event latches into sub pending even when its sub-mask bit is 1, but it does not drive the parent line until that sub-mask bit is cleared.
- R10: Writing 1s to address 3 clears sub-pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Main interrupt source events |
| sub_i | input | 11 | Sub-source events |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A hardware event and a software write-1-to-clear can reach the same source-pending bit in the same cycle. The bench sets a bit, then in one cycle both drives that source line and writes a clear for the same bit. It then reads the register back and expects the bit still set; a clear with no event must zero the bit. A second collision is provoked by making a lower source pending while the interrupt-pending register is full, and the bench expects the held bit to stay unchanged until software clears it.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int NUM_SRC  = 32;
  localparam int NUM_SUB  = 11;
  localparam int NUM_GRP  = 4;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_SRCP   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_INTP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SUBP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SUBM   = 3'd4;
  localparam logic [ADDR_W-1:0] A_SRCSET = 3'd5;

  localparam logic [NUM_SRC-1:0] RSV_MASK = (NUM_SRC'(1) << 6) | (NUM_SRC'(1) << 24);

  // sub-source grouping: first bit, width, parent main line
  localparam int GRP_LO   [NUM_GRP] = '{0, 3, 6, 9};
  localparam int GRP_W    [NUM_GRP] = '{3, 3, 3, 2};
  localparam int GRP_LINE [NUM_GRP] = '{28, 23, 15, 31};

  function automatic logic [NUM_SRC-1:0] parent_lines();
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int g = 0; g < NUM_GRP; g++) m[GRP_LINE[g]] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] PARENT_MASK = parent_lines();
endpackage

// File: rtl/casc_irq_sub.sv
module casc_irq_sub
  import casc_irq_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int NB = NUM_SUB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] sub_i,
  input  logic [NB-1:0] clr_i,
  input  logic          mask_we_i,
  input  logic [NB-1:0] mask_wdata_i,
  output logic [NB-1:0] sub_pend_o,
  output logic [NB-1:0] sub_mask_o,
  output logic [NS-1:0] parent_o
);
  logic [NB-1:0]      pend_q, mask_q, act;
  logic [NUM_GRP-1:0] grp_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= (pend_q & ~clr_i) | sub_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign act = pend_q & ~mask_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_req[g] = |act[GRP_LO[g] +: GRP_W[g]];
  end

  always_comb begin
    parent_o = '0;
    for (int g = 0; g < NUM_GRP; g++) parent_o[GRP_LINE[g]] = parent_o[GRP_LINE[g]] | grp_req[g];
  end

  assign sub_pend_o = pend_q;
  assign sub_mask_o = mask_q;
endmodule

// File: rtl/casc_irq_srcp.sv
module casc_irq_srcp
  import casc_irq_pkg::*;
#(
  parameter int NS = NUM_SRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] ev_i,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] pend_o
);
  logic [NS-1:0] pend_q;

  // events and sets dominate a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q & ~clr_i) | ev_i | set_i) & ~RSV_MASK;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/casc_irq_arb.sv
module casc_irq_arb
  import casc_irq_pkg::*;
#(
  parameter int NS = NUM_SRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] src_pend_i,
  input  logic [NS-1:0] mask_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] int_pend_o
);
  logic [NS-1:0] cand, pick, int_q;

  assign cand = src_pend_i & ~mask_i;
  assign pick = cand & (~cand + NS'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          int_q <= '0;
    else if (int_q == '0) int_q <= pick;
    else                  int_q <= int_q & ~clr_i;
  end

  assign int_pend_o = int_q;
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int NB = NUM_SUB,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] src_i,
  input  logic [NB-1:0] sub_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [NS-1:0] reg_wdata_i,
  output logic [NS-1:0] reg_rdata_o,
  output logic          irq_o
);
  logic [NS-1:0] src_pend, int_pend, main_mask, parent_ev, main_ev;
  logic [NS-1:0] srcp_clr, srcp_set, intp_clr;
  logic [NB-1:0] sub_pend, sub_mask, subp_clr;
  logic          subm_we;

  always_comb begin
    srcp_clr = '0;
    srcp_set = '0;
    intp_clr = '0;
    subp_clr = '0;
    subm_we  = 1'b0;
    if (reg_we_i) begin
      unique case (reg_addr_i)
        A_SRCP:   srcp_clr = reg_wdata_i;
        A_SRCSET: srcp_set = reg_wdata_i;
        A_INTP:   intp_clr = reg_wdata_i;
        A_SUBP:   subp_clr = reg_wdata_i[NB-1:0];
        A_SUBM:   subm_we  = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           main_mask <= '1;
    else if (reg_we_i && reg_addr_i == A_MASK) main_mask <= reg_wdata_i;
  end

  casc_irq_sub #(.NS(NS), .NB(NB)) i_sub (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sub_i        (sub_i),
    .clr_i        (subp_clr),
    .mask_we_i    (subm_we),
    .mask_wdata_i (reg_wdata_i[NB-1:0]),
    .sub_pend_o   (sub_pend),
    .sub_mask_o   (sub_mask),
    .parent_o     (parent_ev)
  );

  // cascaded lines take only their sub-source group
  assign main_ev = (src_i & ~PARENT_MASK) | parent_ev;

  casc_irq_srcp #(.NS(NS)) i_srcp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (main_ev),
    .set_i  (srcp_set),
    .clr_i  (srcp_clr),
    .pend_o (src_pend)
  );

  casc_irq_arb #(.NS(NS)) i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_pend_i (src_pend),
    .mask_i     (main_mask),
    .clr_i      (intp_clr),
    .int_pend_o (int_pend)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_SRCP:  reg_rdata_o = src_pend;
      A_MASK:  reg_rdata_o = main_mask;
      A_INTP:  reg_rdata_o = int_pend;
      A_SUBP:  reg_rdata_o = {{(NS-NB){1'b0}}, sub_pend};
      A_SUBM:  reg_rdata_o = {{(NS-NB){1'b0}}, sub_mask};
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |int_pend;
endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk
  import casc_irq_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NS-1:0] src_i,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [NS-1:0] src_pend,
  input logic [NS-1:0] int_pend,
  input logic [NS-1:0] main_mask,
  input logic          irq_o
);
  localparam logic [NS-1:0] DIRECT = ~(RSV_MASK | PARENT_MASK);

  assert_reserved_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_pend & RSV_MASK) == '0);

  assert_event_beats_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i & DIRECT) != '0 |=> (src_pend & $past(src_i & DIRECT)) == $past(src_i & DIRECT));

  assert_masked_not_loaded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pend == '0 |=> (int_pend & $past(main_mask)) == '0);

  assert_single_winner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(int_pend));

  assert_hold_until_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pend != '0 && !(reg_we_i && reg_addr_i == A_INTP)) |=> $stable(int_pend));

  assert_irq_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_we_i && reg_addr_i == A_INTP));
endmodule

bind casc_irq_ctrl casc_irq_chk #(.NS(NS), .AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .src_pend   (src_pend),
  .int_pend   (int_pend),
  .main_mask  (main_mask),
  .irq_o      (irq_o)
);

// File: tb/test_casc_irq_ctrl.sv
module test_casc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [10:0] sub = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] RSV = 32'h0100_0040;
  localparam logic [31:0] PAR = 32'h9080_8000;

  // {src pattern, main mask, expected interrupt pending}
  localparam logic [95:0] VEC [8] = '{
    {32'h0000_0005, 32'h0000_0000, 32'h0000_0001},
    {32'h0000_0005, 32'h0000_0001, 32'h0000_0004},
    {32'h0000_0048, 32'h0000_0000, 32'h0000_0008},
    {32'h0000_0040, 32'h0000_0000, 32'h0000_0000},
    {32'h0100_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h4000_0000, 32'h0000_0000, 32'h4000_0000},
    {32'h4000_0100, 32'h0000_0100, 32'h4000_0000},
    {32'h0000_3000, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  always #10 clk = ~clk;

  casc_irq_ctrl i_casc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sub_i(sub),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_src(logic [31:0] v);
    @(negedge clk); src = v;
    @(negedge clk); src = '0;
  endtask

  task automatic pulse_sub(logic [10:0] v);
    @(negedge clk); sub = v;
    @(negedge clk); sub = '0;
  endtask

  task automatic clean();
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0000_07FF);
    wr(3'd3, 32'h0000_07FF);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic sub_route(int b, int line);
    logic [31:0] d;
    clean();
    wr(3'd4, 32'h7FF & ~(32'd1 << b));
    pulse_sub(11'd1 << b);
    @(negedge clk);
    rd(3'd0, d); check("R8 group route", d, 32'd1 << line);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, d); check("R1 main mask", d, 32'hFFFF_FFFF);
    rd(3'd4, d); check("R1 sub mask", d, 32'h0000_07FF);
    rd(3'd0, d); check("R1 src pend", d, 32'h0);
    rd(3'd2, d); check("R1 int pend", d, 32'h0);
    rd(3'd3, d); check("R1 sub pend", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // table: R2 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      clean();
      wr(3'd1, VEC[i][63:32]);
      pulse_src(VEC[i][95:64]);
      rd(3'd0, d); check("R2/R5 src pend latch", d, VEC[i][95:64] & ~(RSV | PAR));
      @(negedge clk);
      rd(3'd2, d); check("R6 int pend pick", d, VEC[i][31:0]);
      check("R7 irq level", {31'd0, irq}, {31'd0, VEC[i][31:0] != 0});
    end

    // R4 event versus clear in the same cycle
    clean();
    pulse_src(32'h4);
    @(negedge clk); src = 32'h4; we = 1'b1; addr = 3'd0; wdata = 32'h4;
    @(negedge clk); src = '0; we = 1'b0;
    rd(3'd0, d); check("R4 event wins", d, 32'h4);
    wr(3'd0, 32'h4);
    rd(3'd0, d); check("R3 w1c src pend", d, 32'h0);

    // R3 set register, R2 reserved via set
    wr(3'd5, 32'h0100_0041);
    rd(3'd0, d); check("R3/R2 set", d, 32'h1);
    rd(3'd5, d); check("R3 set reads zero", d, 32'h0);

    // R6 hold while full, R7 acknowledge
    clean();
    wr(3'd1, 32'h0);
    pulse_src(32'h20);
    @(negedge clk);
    rd(3'd2, d); check("R6 first load", d, 32'h20);
    pulse_src(32'h2);
    @(negedge clk);
    rd(3'd2, d); check("R6 held when full", d, 32'h20);
    wr(3'd2, 32'h20);
    @(negedge clk);
    rd(3'd2, d); check("R6 reload lowest", d, 32'h2);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'h2);
    @(negedge clk);
    rd(3'd2, d); check("R7 next after ack", d, 32'h20);
    wr(3'd0, 32'h20);
    wr(3'd2, 32'h20);
    @(negedge clk);
    rd(3'd2, d); check("R7 empty after ack", d, 32'h0);
    check("R7 irq low", {31'd0, irq}, 32'h0);

    // R8 cascade through to irq (port 1 transmit)
    clean();
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h7EF);
    pulse_sub(11'h010);
    rd(3'd3, d); check("R8 sub latch", d, 32'h10);
    @(negedge clk);
    @(negedge clk);
    rd(3'd2, d); check("R8 parent int", d, 32'h0080_0000);
    check("R8 irq", {31'd0, irq}, 32'h1);

    sub_route(2, 28);
    sub_route(5, 23);
    sub_route(6, 15);
    sub_route(10, 31);

    clean();
    pulse_src(32'h8000_8000);
    rd(3'd0, d); check("R8 raw parent ignored", d, 32'h0);

    // R9 masked sub-source
    clean();
    pulse_sub(11'h200);
    @(negedge clk);
    rd(3'd3, d); check("R9 masked sub latches", d, 32'h200);
    rd(3'd0, d); check("R9 masked no parent", d, 32'h0);
    wr(3'd4, 32'h5FF);
    @(negedge clk);
    rd(3'd0, d); check("R9 unmask feeds parent", d, 32'h8000_0000);

    // R10 sub pend clear
    wr(3'd3, 32'h200);
    rd(3'd3, d); check("R10 sub w1c", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule